// File: doc/BRIEF.md
# RAM Parity and Write Protect Guard

This block sits beside the byte-wide data path between a processor and its dynamic RAM. On every processor write it computes one parity bit from the outgoing byte, and the RAM stores that bit next to the byte. On a read, a second tree that shares no logic with the first combines the returned byte with its stored bit. When the result does not match, the block latches a pending error. The pending error drives an interrupt request that the processor cannot mask.

Three controls shape the behaviour. A manual write-protect switch suppresses the RAM write strobe, so neither the byte nor its parity bit changes. A manual parity-off switch removes error reporting completely. An inhibit line from the address-mapping logic blocks error capture while firmware reads locations that may never have been written, for example when it probes memory at power-on to tell a cold start from a manual reset. A pending error stays until the processor writes the clear strobe.

Top module: `ram_parity_guard`

## Requirements
- R1: `ram_wpar` is the parity bit that makes the total count of ones in {`cpu_wdata`, `ram_wpar`} odd (with the default ODD_PAR = 1).
- R2: `ram_we` is high in the same cycle whenever `cpu_sel` = 1, `cpu_rnw` = 0 (0 means write) and `wr_prot` = 0.
- R3: While `wr_prot` = 1, `ram_we` stays low for any strobe pattern, so neither the byte nor its parity bit is stored.
- R4: A read is sampled at a rising clock edge where `cpu_sel` = 1, `cpu_rnw` = 1 and `cpu_dvalid` = 1. If the count of ones in {`ram_rdata`, `ram_rpar`} is even, an error is pending from that edge on, and `nmi_req` is high one edge after the read is sampled.
- R5: A read with matching parity, or with `cpu_dvalid` = 0, does not set the pending error.
- R6: A pending error holds `nmi_req` high until a rising edge sees `err_clr` = 1, and `nmi_req` is low after that edge.
- R7: A parity mismatch sampled while `err_inhib` = 1 does not set the pending error.
- R8: While `par_dis` = 1, no mismatch is captured and `nmi_req` is forced low. An error that was already pending reappears on `nmi_req` when `par_dis` returns to 0.
- R9: If a new error and `err_clr` fall on the same edge, the error remains pending.
- R10: After reset, no error is pending and `nmi_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_sel | input | 1 | RAM access selected this cycle |
| cpu_rnw | input | 1 | 1 = read, 0 = write |
| cpu_dvalid | input | 1 | Read data valid; read parity is sampled at this edge |
| cpu_wdata | input | DATA_W | Byte written by the processor |
| ram_rdata | input | DATA_W | Byte returned by the RAM |
| ram_rpar | input | 1 | Stored parity bit returned by the RAM |
| wr_prot | input | 1 | Manual write-protect switch |
| par_dis | input | 1 | Manual parity reporting off switch |
| err_inhib | input | 1 | Error capture inhibit from mapping logic |
| err_clr | input | 1 | Processor write to the error clear register |
| ram_we | output | 1 | RAM write strobe for byte and parity bit |
| ram_wpar | output | 1 | Parity bit to store with the byte |
| nmi_req | output | 1 | Non-maskable interrupt request |

## Verification
The bench builds the guard with its default parameters: an 8-bit data path and odd parity. At that width, the bench can reach both boundary data values (all zeros and all ones) and patterns with odd and even counts of ones. The bench also covers every combination that matters of sample strobe, inhibit, parity-off and clear, including an error and a clear that arrive on the same edge, and a parity-off period laid over an error that is already pending.

// File: rtl/rpg_pkg.sv
package rpg_pkg;
  // Turn a plain XOR reduction into the stored parity bit.
  function automatic logic par_from_xor(input logic xr, input bit odd_sense);
    return odd_sense ? ~xr : xr;
  endfunction

  // A read word (data plus stored bit) is bad when its XOR disagrees with the sense.
  function automatic logic word_bad(input logic xr, input bit odd_sense);
    return odd_sense ? ~xr : xr;
  endfunction

  // Levels in a balanced two-input tree over w leaves.
  function automatic int tree_levels(input int w);
    return (w <= 1) ? 1 : $clog2(w);
  endfunction
endpackage

// File: rtl/rpg_xor_tree.sv
module rpg_xor_tree #(
  parameter int W = 8
) (
  input  logic [W-1:0] in_bits,
  output logic         red
);
  localparam int LVL = rpg_pkg::tree_levels(W);
  localparam int P   = 1 << LVL;

  genvar lv, g;
  for (lv = 0; lv <= LVL; lv++) begin : stage
    localparam int NW = P >> lv;
    logic [NW-1:0] v;
    if (lv == 0) begin : g_leaf
      for (g = 0; g < P; g++) begin : g_pad
        if (g < W) begin : g_in
          assign v[g] = in_bits[g];
        end else begin : g_zero
          assign v[g] = 1'b0;
        end
      end
    end else begin : g_node
      for (g = 0; g < NW; g++) begin : g_x
        assign v[g] = stage[lv-1].v[2*g] ^ stage[lv-1].v[2*g+1];
      end
    end
  end

  assign red = stage[LVL].v[0];
endmodule

// File: rtl/rpg_par_gen.sv
module rpg_par_gen #(
  parameter int DATA_W  = 8,
  parameter bit ODD_PAR = 1'b1
) (
  input  logic [DATA_W-1:0] wdata,
  output logic              wpar
);
  logic gen_xor_w;

  rpg_xor_tree #(.W(DATA_W)) u_gen_tree (
    .in_bits (wdata),
    .red     (gen_xor_w)
  );

  assign wpar = rpg_pkg::par_from_xor(gen_xor_w, ODD_PAR);
endmodule

// File: rtl/rpg_par_chk.sv
module rpg_par_chk #(
  parameter int DATA_W  = 8,
  parameter bit ODD_PAR = 1'b1
) (
  input  logic [DATA_W-1:0] rdata,
  input  logic              rpar,
  output logic              bad
);
  localparam int CW = DATA_W + 1;
  logic chk_xor_w;

  rpg_xor_tree #(.W(CW)) u_chk_tree (
    .in_bits ({rpar, rdata}),
    .red     (chk_xor_w)
  );

  assign bad = rpg_pkg::word_bad(chk_xor_w, ODD_PAR);
endmodule

// File: rtl/rpg_err_latch.sv
module rpg_err_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic samp,
  input  logic bad,
  input  logic inhib,
  input  logic dis,
  input  logic clr,
  output logic pend
);
  logic set_w;
  assign set_w = samp & bad & ~inhib & ~dis;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend <= 1'b0;
    else if (set_w)  pend <= 1'b1;
    else if (clr)    pend <= 1'b0;
  end

  // R4
  set_on_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    samp && bad && !inhib && !dis |=> pend);
  // R6
  hold_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend && !clr |=> pend);
  // R6
  clr_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend && clr && !(samp && bad && !inhib && !dis) |=> !pend);
  // R7
  inhib_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pend && inhib |=> !pend);
  // R5
  no_set_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pend && !(samp && bad) |=> !pend);
endmodule

// File: rtl/ram_parity_guard.sv
module ram_parity_guard #(
  parameter int DATA_W  = 8,
  parameter bit ODD_PAR = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_sel,
  input  logic              cpu_rnw,
  input  logic              cpu_dvalid,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic [DATA_W-1:0] ram_rdata,
  input  logic              ram_rpar,
  input  logic              wr_prot,
  input  logic              par_dis,
  input  logic              err_inhib,
  input  logic              err_clr,
  output logic              ram_we,
  output logic              ram_wpar,
  output logic              nmi_req
);
  // Named internal events for the checks.
  logic wr_cyc_w, rd_samp_w, rd_bad_w, pend_w;

  assign wr_cyc_w  = cpu_sel & ~cpu_rnw;
  assign rd_samp_w = cpu_sel & cpu_rnw & cpu_dvalid;

  rpg_par_gen #(.DATA_W(DATA_W), .ODD_PAR(ODD_PAR)) u_gen (
    .wdata (cpu_wdata),
    .wpar  (ram_wpar)
  );

  rpg_par_chk #(.DATA_W(DATA_W), .ODD_PAR(ODD_PAR)) u_chk (
    .rdata (ram_rdata),
    .rpar  (ram_rpar),
    .bad   (rd_bad_w)
  );

  rpg_err_latch u_err (
    .clk   (clk),
    .rst_n (rst_n),
    .samp  (rd_samp_w),
    .bad   (rd_bad_w),
    .inhib (err_inhib),
    .dis   (par_dis),
    .clr   (err_clr),
    .pend  (pend_w)
  );

  assign ram_we  = wr_cyc_w & ~wr_prot;
  assign nmi_req = pend_w & ~par_dis;

  // R1
  gen_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($countones({cpu_wdata, ram_wpar}) % 2) == (ODD_PAR ? 1 : 0)));
  // R3
  wp_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_prot |-> !ram_we);
  // R8
  dis_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_dis |-> !nmi_req);
  // R8
  dis_no_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_w && par_dis |=> !pend_w);
endmodule

// File: tb/ram_parity_guard_tb.sv
module ram_parity_guard_tb;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_sel = 0, cpu_rnw = 1, cpu_dvalid = 0;
  logic [DW-1:0] cpu_wdata = '0, ram_rdata = '0;
  logic ram_rpar = 0, wr_prot = 0, par_dis = 0, err_inhib = 0, err_clr = 0;
  logic ram_we, ram_wpar, nmi_req;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  ram_parity_guard #(.DATA_W(DW), .ODD_PAR(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_rnw(cpu_rnw),
    .cpu_dvalid(cpu_dvalid), .cpu_wdata(cpu_wdata), .ram_rdata(ram_rdata),
    .ram_rpar(ram_rpar), .wr_prot(wr_prot), .par_dis(par_dis),
    .err_inhib(err_inhib), .err_clr(err_clr), .ram_we(ram_we),
    .ram_wpar(ram_wpar), .nmi_req(nmi_req)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Bench's own parity: count ones and pick the bit that makes the total odd.
  function automatic logic odd_bit(input logic [DW-1:0] d);
    int c = 0;
    for (int i = 0; i < DW; i++) if (d[i]) c++;
    return (c % 2 == 0) ? 1'b1 : 1'b0;
  endfunction

  task automatic idle();
    @(negedge clk);
    cpu_sel = 0; cpu_rnw = 1; cpu_dvalid = 0; err_clr = 0;
  endtask

  // Present a read for one edge; result visible at the following negedge.
  task automatic read_cyc(input logic [DW-1:0] d, input logic p, input logic dv);
    @(negedge clk);
    cpu_sel = 1; cpu_rnw = 1; cpu_dvalid = dv; ram_rdata = d; ram_rpar = p;
    @(negedge clk);
    cpu_sel = 0; cpu_dvalid = 0;
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    err_clr = 1;
    @(negedge clk);
    err_clr = 0;
  endtask

  task automatic t_reset();
    #1;
    check("R10 nmi after reset", nmi_req, 1'b0);
    rst_n = 1;
    @(negedge clk);
    check("R10 nmi idle", nmi_req, 1'b0);
  endtask

  task automatic t_write_parity();
    logic [DW-1:0] pats [6] = '{8'h00, 8'hFF, 8'h01, 8'hA5, 8'h7F, 8'h80};
    foreach (pats[i]) begin
      @(negedge clk);
      cpu_sel = 1; cpu_rnw = 0; cpu_wdata = pats[i];
      #1;
      check("R1 write parity", ram_wpar, odd_bit(pats[i]));
      check("R2 write strobe", ram_we, 1'b1);
    end
    idle();
    #1;
    check("R2 no strobe when idle", ram_we, 1'b0);
  endtask

  task automatic t_write_protect();
    @(negedge clk);
    wr_prot = 1; cpu_sel = 1; cpu_rnw = 0; cpu_wdata = 8'h3C;
    #1;
    check("R3 protected write", ram_we, 1'b0);
    @(negedge clk);
    cpu_wdata = 8'hC1;
    #1;
    check("R3 protected write 2", ram_we, 1'b0);
    idle();
    wr_prot = 0;
  endtask

  task automatic t_good_reads();
    read_cyc(8'h03, 1'b1, 1'b1);
    check("R5 good read", nmi_req, 1'b0);
    read_cyc(8'hFF, 1'b1, 1'b1);
    check("R5 good read all ones", nmi_req, 1'b0);
    read_cyc(8'h03, 1'b0, 1'b0);
    check("R5 bad data without dvalid", nmi_req, 1'b0);
  endtask

  task automatic t_bad_read_and_clear();
    read_cyc(8'h03, 1'b0, 1'b1);
    check("R4 mismatch raises nmi", nmi_req, 1'b1);
    repeat (3) @(negedge clk);
    check("R6 nmi held", nmi_req, 1'b1);
    pulse_clr();
    check("R6 nmi cleared", nmi_req, 1'b0);
    read_cyc(8'h00, 1'b0, 1'b1);
    check("R4 zero byte zero parity", nmi_req, 1'b1);
    pulse_clr();
    check("R6 cleared again", nmi_req, 1'b0);
  endtask

  task automatic t_inhibit();
    err_inhib = 1;
    read_cyc(8'h55, 1'b0, 1'b1);
    check("R7 inhibited mismatch", nmi_req, 1'b0);
    err_inhib = 0;
    @(negedge clk);
    check("R7 nothing pending after inhibit", nmi_req, 1'b0);
  endtask

  task automatic t_disable();
    par_dis = 1;
    read_cyc(8'h0F, 1'b0, 1'b1);
    check("R8 disabled mismatch", nmi_req, 1'b0);
    par_dis = 0;
    @(negedge clk);
    check("R8 none pending after disable", nmi_req, 1'b0);
    read_cyc(8'h0F, 1'b0, 1'b1);
    check("R8 pending before disable", nmi_req, 1'b1);
    par_dis = 1;
    #1;
    check("R8 disable masks nmi", nmi_req, 1'b0);
    @(negedge clk);
    par_dis = 0;
    #1;
    check("R8 pending returns", nmi_req, 1'b1);
    pulse_clr();
  endtask

  task automatic t_set_wins();
    @(negedge clk);
    cpu_sel = 1; cpu_rnw = 1; cpu_dvalid = 1; ram_rdata = 8'h11; ram_rpar = 0;
    err_clr = 1;
    @(negedge clk);
    cpu_sel = 0; cpu_dvalid = 0; err_clr = 0;
    check("R9 set beats clear", nmi_req, 1'b1);
    pulse_clr();
    check("R9 later clear works", nmi_req, 1'b0);
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_write_parity();
    t_write_protect();
    t_good_reads();
    t_bad_read_and_clear();
    t_inhibit();
    t_disable();
    t_set_wins();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule